// File: doc/BRIEF.md
# Seconds Counter with Match Alarm

This block is a register-mapped real-time clock core. A free-running 32768 Hz tick strobe is divided by a prescaler so that a binary seconds counter advances once per second while the counter is enabled. Software sets the time by writing a dedicated write-only load register. It reads the running time back from a separate data register.

A match register holds an alarm time. When the counter steps onto that value, a sticky raw alarm flag sets. The flag is gated by an interrupt mask to form the masked status and the single interrupt output. Software removes a pending alarm by writing a 1 to bit 0 of the clear register.

Access is through a single-cycle write strobe with a byte offset. Read data is registered from the offset presented in the previous cycle.

Top module: `rtc_alarm_core`

## Requirements
- R1: After reset the count, match, control, mask and raw alarm all read 0 and `irq` is 0.
- R2: Registers sit at the following byte offsets. Offset 0x00 is the count (read), 0x04 the match (read/write) and 0x08 the load (write). Offset 0x0C is the control register, with run enable in bit 0. Offset 0x10 is the mask (bit 0), 0x14 the raw status (bit 0), 0x18 the masked status (bit 0) and 0x1C the clear register (write, bit 0). All other bits of the single-bit registers read 0. `rdata` shows the register addressed one cycle earlier.
- R3: While control bit 0 is 0, ticks change neither the count nor the prescaler phase.
- R4: While enabled, the count increases by one on every 2^PRE_W-th tick.
- R5: Writing the load register replaces the count and restarts the prescaler at zero. A load in the same cycle as a step takes priority.
- R6: The count wraps from all ones to zero.
- R7: The raw alarm sets when the counter steps onto the match value. A load of the match value does not set it.
- R8: The raw alarm stays set until a clear write with bit 0 = 1. A clear write with bit 0 = 0 has no effect.
- R9: If a set and a clear occur in the same cycle, the raw alarm ends set.
- R10: Masked status equals raw AND mask, and `irq` equals the masked status.
- R11: The load offset, the clear offset, unmapped offsets and offsets not aligned to a word all read 0. Writes to unmapped or misaligned offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle strobe of the 32768 Hz timebase |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Byte offset of the access |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Alarm interrupt, active high |

## Verification
The assertions assume that `tick` is a single-cycle strobe sampled on `clk`. They also assume that at most one register write happens per cycle, which holds because there is a single strobe. The bench drives every input on the falling edge and keeps each tick pulse one cycle wide. It runs a 2-bit prescaler, so each second takes four ticks and whole step sequences, wrap and alarm coincidences can be swept quickly. Every offset from 0 to 31 is read so that the zero-read rule is covered without gaps.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
  localparam int ADDR_W = 5;
  localparam logic [ADDR_W-1:0] OFS_COUNT  = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_MATCH  = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_LOAD   = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_CTRL   = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_MASK   = 5'h10;
  localparam logic [ADDR_W-1:0] OFS_RAW    = 5'h14;
  localparam logic [ADDR_W-1:0] OFS_MASKED = 5'h18;
  localparam logic [ADDR_W-1:0] OFS_CLEAR  = 5'h1C;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int PRE_W = 15
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic tick,
  input  logic restart,
  output logic step
);
  logic [PRE_W-1:0] phase;

  always_ff @(posedge clk) begin
    if (rst)              phase <= '0;
    else if (restart)     phase <= '0;
    else if (run && tick) phase <= phase + 1'b1;
  end

  assign step = run && tick && (&phase);

  assert_prescale_restart_R5: assert property (@(posedge clk) disable iff (rst)
    restart |=> (phase == '0));
  assert_prescale_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!run && !restart) |=> $stable(phase));
endmodule

// File: rtl/rtc_seconds_counter.sv
module rtc_seconds_counter #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  input  logic [DATA_W-1:0] match,
  output logic [DATA_W-1:0] count,
  output logic              hit
);
  logic [DATA_W-1:0] next_up;
  assign next_up = count + 1'b1;

  always_ff @(posedge clk) begin
    if (rst)       count <= '0;
    else if (load) count <= load_val;
    else if (step) count <= next_up;
  end

  assign hit = step && !load && (next_up == match);

  assert_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    (step && !load && (&count)) |=> (count == '0));
  assert_load_wins_R5: assert property (@(posedge clk) disable iff (rst)
    load |=> (count == $past(load_val)));
endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  input  logic mask_wr,
  input  logic mask_val,
  output logic raw,
  output logic mask,
  output logic irq
);
  logic raw_d, mask_d;

  assign raw_d  = set || (raw && !clr);
  assign mask_d = mask_wr ? mask_val : mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      raw  <= 1'b0;
      mask <= 1'b0;
      irq  <= 1'b0;
    end else begin
      raw  <= raw_d;
      mask <= mask_d;
      irq  <= raw_d && mask_d;
    end
  end

  assert_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (raw && !clr) |=> raw);
  assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
    set |=> raw);
  assert_irq_gate_R10: assert property (@(posedge clk) disable iff (rst)
    irq == (raw && mask));
endmodule

// File: rtl/rtc_alarm_core.sv
module rtc_alarm_core
  import rtc_alarm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PRE_W  = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [4:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  logic              wr_match, wr_load, wr_ctrl, wr_mask, wr_clear;
  logic              run_en;
  logic [DATA_W-1:0] match_q;
  logic [DATA_W-1:0] count;
  logic              step, hit, raw, mask;

  assign wr_match = wr_en && (addr == OFS_MATCH);
  assign wr_load  = wr_en && (addr == OFS_LOAD);
  assign wr_ctrl  = wr_en && (addr == OFS_CTRL);
  assign wr_mask  = wr_en && (addr == OFS_MASK);
  assign wr_clear = wr_en && (addr == OFS_CLEAR);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_en  <= 1'b0;
      match_q <= '0;
    end else begin
      if (wr_ctrl)  run_en  <= wdata[0];
      if (wr_match) match_q <= wdata;
    end
  end

  rtc_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .run(run_en), .tick(tick),
    .restart(wr_load), .step(step)
  );

  rtc_seconds_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk(clk), .rst(rst), .step(step), .load(wr_load),
    .load_val(wdata), .match(match_q), .count(count), .hit(hit)
  );

  rtc_alarm_irq u_alm (
    .clk(clk), .rst(rst), .set(hit), .clr(wr_clear && wdata[0]),
    .mask_wr(wr_mask), .mask_val(wdata[0]),
    .raw(raw), .mask(mask), .irq(irq)
  );

  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    unique case (addr)
      OFS_COUNT:  rd_mux = count;
      OFS_MATCH:  rd_mux = match_q;
      OFS_CTRL:   rd_mux[0] = run_en;
      OFS_MASK:   rd_mux[0] = mask;
      OFS_RAW:    rd_mux[0] = raw;
      OFS_MASKED: rd_mux[0] = raw & mask;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end

  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!run_en && !wr_load) |=> $stable(count));
  assert_no_spurious_alarm_R7: assert property (@(posedge clk) disable iff (rst)
    (!raw && !hit) |=> !raw);
  assert_match_stable_R11: assert property (@(posedge clk) disable iff (rst)
    !wr_match |=> $stable(match_q));
endmodule

// File: tb/rtc_alarm_core_test.sv
module rtc_alarm_core_test;
  localparam int DW = 32;
  localparam int PW = 2;
  localparam int TPS = 1 << PW;

  logic          clk = 0, rst = 1, tick = 0, wr_en = 0;
  logic [4:0]    addr = 0;
  logic [DW-1:0] wdata = 0;
  logic [DW-1:0] rdata;
  logic          irq;
  int n_chk = 0, n_bad = 0;

  rtc_alarm_core #(.DATA_W(DW), .PRE_W(PW)) uut (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  always #2 clk = ~clk;

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [DW-1:0] d, logic t = 0);
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d; tick = t;
    @(negedge clk);
    wr_en = 0; tick = 0;
  endtask

  task automatic rd(logic [4:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    d = rdata;
  endtask

  task automatic tk(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
    end
  endtask

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] v;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    rd(5'h00, v); chk("R1 count", v, 0);
    rd(5'h04, v); chk("R1 match", v, 0);
    rd(5'h0C, v); chk("R1 ctrl", v, 0);
    rd(5'h10, v); chk("R1 mask", v, 0);
    rd(5'h14, v); chk("R1 raw", v, 0);
    chk("R1 irq", irq, 0);
    // R3 disabled: ticks do nothing
    tk(9); rd(5'h00, v); chk("R3 disabled count", v, 0);
    // R2 register readback
    wr(5'h04, 32'h1234_5678); rd(5'h04, v); chk("R2 match", v, 32'h1234_5678);
    wr(5'h0C, '1); rd(5'h0C, v); chk("R2 ctrl bit0 only", v, 1);
    wr(5'h10, 32'hFFFF_FFFE); rd(5'h10, v); chk("R2 mask bit0", v, 0);
    // R4 step sweep
    wr(5'h08, 0);
    for (int i = 1; i <= 5 * TPS; i++) begin
      tk(1); rd(5'h00, v); chk("R4 step sweep", v, i / TPS);
    end
    // R3 prescaler phase held while disabled
    wr(5'h08, 0); tk(2); wr(5'h0C, 0); tk(5); wr(5'h0C, 1); tk(TPS - 3);
    rd(5'h00, v); chk("R3 phase held", v, 0);
    tk(1); rd(5'h00, v); chk("R3 phase resumes", v, 1);
    // R5 load restarts prescaler
    tk(TPS - 1); wr(5'h08, 100); tk(TPS - 1);
    rd(5'h00, v); chk("R5 restart", v, 100);
    tk(1); rd(5'h00, v); chk("R5 restart step", v, 101);
    // R5 load wins over simultaneous step
    tk(TPS - 1); wr(5'h08, 50, 1'b1);
    rd(5'h00, v); chk("R5 load priority", v, 50);
    tk(TPS); rd(5'h00, v); chk("R5 after priority", v, 51);
    // R6 wrap
    wr(5'h08, '1); tk(TPS); rd(5'h00, v); chk("R6 wrap", v, 0);
    // R7 alarm on step to match
    wr(5'h04, 5); wr(5'h10, 0); wr(5'h1C, 1); wr(5'h08, 3);
    tk(TPS); rd(5'h14, v); chk("R7 not yet", v, 0);
    tk(TPS); rd(5'h14, v); chk("R7 raw set", v, 1);
    rd(5'h18, v); chk("R10 masked off", v, 0);
    chk("R10 irq masked", irq, 0);
    wr(5'h10, 1); rd(5'h18, v); chk("R10 masked on", v, 1);
    chk("R10 irq on", irq, 1);
    // R8 clear semantics
    wr(5'h1C, 32'hFFFF_FFFE); rd(5'h14, v); chk("R8 clear bit0=0", v, 1);
    wr(5'h1C, 1); rd(5'h14, v); chk("R8 cleared", v, 0);
    chk("R10 irq cleared", irq, 0);
    // R7 load onto match does not set
    wr(5'h08, 5); rd(5'h14, v); chk("R7 load no set", v, 0);
    // R9 set and clear together
    wr(5'h04, 6); wr(5'h08, 5); tk(TPS - 1); wr(5'h1C, 1, 1'b1);
    rd(5'h00, v); chk("R9 stepped", v, 6);
    rd(5'h14, v); chk("R9 set wins", v, 1);
    chk("R9 irq", irq, 1);
    wr(5'h1C, 1);
    // R11 zero reads and ignored writes
    wr(5'h20 - 5'h1, '1);
    wr(5'h05, 0);
    rd(5'h04, v); chk("R11 misaligned write", v, 6);
    for (int a = 0; a < 32; a++) begin
      if (a != 0 && a != 4 && a != 12 && a != 16 && a != 20 && a != 24) begin
        rd(a[4:0], v); chk("R11 zero read", v, 0);
      end
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule